// File: doc/BRIEF.md
# Board Interrupt Aggregator Register Block

This peripheral collects sixteen external, level-sensitive interrupt lines from a circuit board and merges them into a single level interrupt towards the processor. Each line passes a two-flop synchronizer. It can then latch into a sticky pending register, but only while the matching bit of an enable register is set. The processor interrupt is raised whenever some pending bit is also enabled. Software acknowledges by overwriting the pending register. Both interrupt registers keep only a fixed set of writable bits, given by the hardwired mask `0x000FEEFF`.

Besides the interrupt path, the block has eight plain 32-bit storage registers, used for LEDs, switches and miscellaneous control. It also has two card-socket status words. In each socket word, software may change only the five low control bits. Bit 5 is an active-low card-detect flag that mirrors one interrupt input. Bit 10 is a read-only "ready" flag that is always 1. All access goes through a simple byte-offset register port. Writes use a one-cycle strobe. Read data is registered and appears one cycle after the read strobe.

The logic has no sequencing: every register updates in one step. Register selection uses a named decode set: the eight plain storage slots, ENABLE, PENDING, SOCKET0, SOCKET1, and NONE for any unmapped offset.

Top module: `board_irq_hub`

## Requirements
- R1: After reset, all storage, enable and pending registers read 0. Both socket words read 0x420. `irq_out` is 0.
- R2: The plain 32-bit registers keep every written bit, each at its own offset: 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88 and 0x90.
- R3: A read at any other offset returns 0. A write to any other offset changes no register.
- R4: A write to the enable register (0xC0) or the pending register (0xD0) stores the data ANDed with 0x000FEEFF. Bits outside that mask always read 0.
- R5: An input that is held high sets its pending bit on the third rising edge after it rises (two synchronizer stages plus the latch). It does so only if the enable bit was already 1 before that edge. An input whose enable bit is 0 never latches.
- R6: Pending bits stay set after their input falls. They change only through a write to 0xD0.
- R7: `irq_out` is 1 exactly when the bitwise AND of the pending and enable registers is nonzero.
- R8: Bit 5 of the socket 0 word (0xE0) is the inverse of synchronized input 9. Bit 5 of the socket 1 word (0xE4) is the inverse of synchronized input 13. Both follow with the same three-edge latency as R5.
- R9: A write to a socket word changes only bits [4:0]. Bit 10 stays 1, bit 5 stays the card-detect flag, and all other bits stay 0.
- R10: When a write to 0xD0 lands in the same cycle as an input latch, the write value wins. An enabled input that is still high latches again on the following edge.
- R11: `rdata` is loaded on the edge where `rd_en` is high. It holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 16 | Asynchronous external interrupt lines, active high |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | One-cycle read strobe |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Merged level interrupt |

## Verification
The storage path is tried with a table of distinct data words written to every plain offset and to an unmapped offset, then read back. This pattern separates offset aliasing from dropped writes. The interrupt path is driven with four patterns, and each tells a different fault apart:
- An enabled line, sampled two and three cycles after it rises. This exposes wrong synchronizer depth.
- A disabled line. This exposes latching that ignores the enable bit.
- A line that falls after it has latched. This exposes pending bits that clear themselves.
- A line that stays high across a pending overwrite. This exposes a wrong write-versus-latch priority.

The card-detect inputs are toggled one socket at a time, which catches crossed socket wiring. All-ones writes to the socket and interrupt registers show any bit that escapes its writable mask.

// File: rtl/hub_pkg.sv
package hub_pkg;
    localparam int REG_W    = 32;
    localparam int ADDR_W   = 8;
    localparam int NUM_IRQ  = 16;
    localparam int GP_NUM   = 8;
    localparam int SOCK_NUM = 2;
    localparam int CTL_W    = 5;
    localparam int CD_BIT   = 5;
    localparam int RDY_BIT  = 10;

    localparam logic [REG_W-1:0] IRQ_WMASK = 32'h000F_EEFF;

    typedef enum logic [3:0] {
        SEL_LED_A   = 4'd0,
        SEL_LED_B   = 4'd1,
        SEL_LED_CTL = 4'd2,
        SEL_SWITCH  = 4'd3,
        SEL_MISC_A  = 4'd4,
        SEL_MISC_B  = 4'd5,
        SEL_MISC_C  = 4'd6,
        SEL_MISC_RD = 4'd7,
        SEL_ENABLE  = 4'd8,
        SEL_PENDING = 4'd9,
        SEL_SOCK0   = 4'd10,
        SEL_SOCK1   = 4'd11,
        SEL_NONE    = 4'd15
    } reg_sel_e;

    function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        unique case (a)
            8'h10:   s = SEL_LED_A;
            8'h14:   s = SEL_LED_B;
            8'h40:   s = SEL_LED_CTL;
            8'h60:   s = SEL_SWITCH;
            8'h80:   s = SEL_MISC_A;
            8'h84:   s = SEL_MISC_B;
            8'h88:   s = SEL_MISC_C;
            8'h90:   s = SEL_MISC_RD;
            8'hC0:   s = SEL_ENABLE;
            8'hD0:   s = SEL_PENDING;
            8'hE0:   s = SEL_SOCK0;
            8'hE4:   s = SEL_SOCK1;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '0;
            sync_out <= '0;
        end else begin
            meta_q   <= async_in;
            sync_out <= meta_q;
        end
    end
endmodule

// File: rtl/irq_pending.sv
module irq_pending
    import hub_pkg::*;
#(
    parameter int NIN = NUM_IRQ
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NIN-1:0]   lines,
    input  logic             wr_enable,
    input  logic             wr_pending,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] enable_q,
    output logic [REG_W-1:0] pending_q,
    output logic             irq_out
);
    localparam int PAD = REG_W - NIN;

    logic [REG_W-1:0] lines_ext;
    assign lines_ext = {{PAD{1'b0}}, lines};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q  <= '0;
            pending_q <= '0;
        end else begin
            if (wr_enable) enable_q <= wdata & IRQ_WMASK;
            if (wr_pending) pending_q <= wdata & IRQ_WMASK;
            else            pending_q <= pending_q | (lines_ext & enable_q);
        end
    end

    assign irq_out = |(pending_q & enable_q);

    // R6
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pending |=> ((pending_q & $past(pending_q)) == $past(pending_q)));

    // R5
    pend_enabled_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pending |=> ((pending_q & ~$past(pending_q) & ~$past(enable_q)) == '0));

    // R4
    pend_wmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pending |=> ((pending_q & ~IRQ_WMASK) == '0));

    // R10
    pend_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pending |=> (pending_q == ($past(wdata) & IRQ_WMASK)));
endmodule

// File: rtl/sock_status.sv
module sock_status
    import hub_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             detect_in,
    input  logic             wr_sock,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] status
);
    logic [CTL_W-1:0] ctl_q;
    logic             absent_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            absent_q <= 1'b1;
        end else begin
            absent_q <= ~detect_in;
            if (wr_sock) ctl_q <= wdata[CTL_W-1:0];
        end
    end

    always_comb begin
        status               = '0;
        status[RDY_BIT]      = 1'b1;
        status[CD_BIT]       = absent_q;
        status[CTL_W-1:0]    = ctl_q;
    end

    // R9
    sock_ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sock |=> $stable(ctl_q));

    // R8
    sock_cd_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(absent_q) |-> $past(detect_in));
endmodule

// File: rtl/board_irq_hub.sv
module board_irq_hub
    import hub_pkg::*;
#(
    parameter int SOCK0_LINE = 9,
    parameter int SOCK1_LINE = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              irq_out
);
    localparam int SOCK_LINE [SOCK_NUM] = '{SOCK0_LINE, SOCK1_LINE};

    reg_sel_e           sel;
    logic [NUM_IRQ-1:0] lines;
    logic [REG_W-1:0]   gp_q     [GP_NUM];
    logic [REG_W-1:0]   sock_word[SOCK_NUM];
    logic [REG_W-1:0]   enable_q, pending_q;
    logic [REG_W-1:0]   rd_mux;

    assign sel = decode_offset(addr);

    irq_sync #(.W(NUM_IRQ)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(irq_in), .sync_out(lines)
    );

    irq_pending #(.NIN(NUM_IRQ)) u_pend (
        .clk(clk), .rst_n(rst_n), .lines(lines),
        .wr_enable(wr_en && sel == SEL_ENABLE),
        .wr_pending(wr_en && sel == SEL_PENDING),
        .wdata(wdata), .enable_q(enable_q), .pending_q(pending_q),
        .irq_out(irq_out)
    );

    for (genvar s = 0; s < SOCK_NUM; s++) begin : g_sock
        sock_status u_sock (
            .clk(clk), .rst_n(rst_n),
            .detect_in(lines[SOCK_LINE[s]]),
            .wr_sock(wr_en && sel == reg_sel_e'(SEL_SOCK0 + s)),
            .wdata(wdata), .status(sock_word[s])
        );
    end

    for (genvar g = 0; g < GP_NUM; g++) begin : g_gp
        always_ff @(posedge clk) begin
            if (!rst_n)                               gp_q[g] <= '0;
            else if (wr_en && sel == reg_sel_e'(g))   gp_q[g] <= wdata;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_LED_A, SEL_LED_B, SEL_LED_CTL, SEL_SWITCH,
            SEL_MISC_A, SEL_MISC_B, SEL_MISC_C, SEL_MISC_RD:
                rd_mux = gp_q[sel[2:0]];
            SEL_ENABLE:  rd_mux = enable_q;
            SEL_PENDING: rd_mux = pending_q;
            SEL_SOCK0:   rd_mux = sock_word[0];
            SEL_SOCK1:   rd_mux = sock_word[1];
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    // R3
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_NONE) |=> (rdata == '0));

    // R7
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> ((pending_q & enable_q) != '0));
endmodule

// File: tb/board_irq_hub_test.sv
module board_irq_hub_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_in = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    board_irq_hub uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq_out(irq_out)
    );

    typedef struct packed {
        logic [7:0]  a;
        logic [31:0] d;
        logic [31:0] e;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{8'h10, 32'hA5A5_0001, 32'hA5A5_0001},
        '{8'h14, 32'h5A5A_0002, 32'h5A5A_0002},
        '{8'h40, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        '{8'h60, 32'h1234_5678, 32'h1234_5678},
        '{8'h80, 32'h8000_0001, 32'h8000_0001},
        '{8'h84, 32'h0F0F_F0F0, 32'h0F0F_F0F0},
        '{8'h88, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
        '{8'h90, 32'h0000_0C0D, 32'h0000_0C0D},
        '{8'h20, 32'hCAFE_F00D, 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] held;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1 reset state
        chk("R1 irq_out", {31'b0, irq_out}, 32'h0);
        bus_rd(8'h10, v); chk("R1 led data", v, 32'h0);
        bus_rd(8'hC0, v); chk("R1 enable", v, 32'h0);
        bus_rd(8'hD0, v); chk("R1 pending", v, 32'h0);
        bus_rd(8'hE0, v); chk("R1 socket0", v, 32'h420);
        bus_rd(8'hE4, v); chk("R1 socket1", v, 32'h420);

        // R2 / R3 table: write all, then read all
        for (int i = 0; i < NV; i++) bus_wr(VEC[i].a, VEC[i].d);
        for (int i = 0; i < NV; i++) begin
            bus_rd(VEC[i].a, v);
            chk(VEC[i].a == 8'h20 ? "R3 unmapped read" : "R2 storage", v, VEC[i].e);
        end
        // R3 unmapped write leaves neighbours alone
        bus_wr(8'h44, 32'h0);
        bus_wr(8'h11, 32'h0);
        bus_rd(8'h40, v); chk("R3 ignored write", v, 32'hFFFF_FFFF);
        bus_rd(8'h10, v); chk("R3 ignored write", v, 32'hA5A5_0001);

        // R11 hold while rd_en low
        bus_rd(8'h60, held);
        @(negedge clk); addr = 8'h10;
        wait_cyc(3);
        chk("R11 rdata hold", rdata, 32'h1234_5678);

        // R4 write masks
        bus_wr(8'hC0, 32'hFFFF_FFFF);
        bus_rd(8'hC0, v); chk("R4 enable mask", v, 32'h000F_EEFF);
        chk("R7 irq low with empty pending", {31'b0, irq_out}, 32'h0);
        bus_wr(8'hD0, 32'hFFFF_FFFF);
        bus_rd(8'hD0, v); chk("R4 pending mask", v, 32'h000F_EEFF);
        chk("R7 irq high", {31'b0, irq_out}, 32'h1);
        bus_wr(8'hC0, 32'h0);
        chk("R7 irq low with enable 0", {31'b0, irq_out}, 32'h0);
        bus_wr(8'hD0, 32'h0);

        // R5 disabled input never latches
        @(negedge clk); irq_in[2] = 1'b1;
        wait_cyc(6);
        bus_rd(8'hD0, v); chk("R5 disabled no latch", v, 32'h0);
        chk("R7 irq low", {31'b0, irq_out}, 32'h0);
        irq_in[2] = 1'b0;
        wait_cyc(4);

        // R5 enabled input: latency of three edges
        bus_wr(8'hC0, 32'h0000_0008);
        irq_in[3] = 1'b1;
        wait_cyc(2);
        chk("R5 not yet latched at edge 2", {31'b0, irq_out}, 32'h0);
        wait_cyc(1);
        chk("R5 latched at edge 3", {31'b0, irq_out}, 32'h1);

        // R10 write vs latch, relatch next cycle
        bus_wr(8'hD0, 32'h0);
        chk("R10 write wins", {31'b0, irq_out}, 32'h0);
        wait_cyc(1);
        chk("R10 relatch", {31'b0, irq_out}, 32'h1);

        // R6 sticky after input falls
        irq_in[3] = 1'b0;
        wait_cyc(5);
        bus_rd(8'hD0, v); chk("R6 sticky", v, 32'h0000_0008);
        bus_wr(8'hD0, 32'h0);
        bus_rd(8'hD0, v); chk("R6 cleared by write", v, 32'h0);
        chk("R7 irq cleared", {31'b0, irq_out}, 32'h0);
        bus_wr(8'hC0, 32'h0);

        // R8 card detect per socket
        irq_in[9] = 1'b1;
        wait_cyc(3);
        bus_rd(8'hE0, v); chk("R8 socket0 present", v, 32'h400);
        bus_rd(8'hE4, v); chk("R8 socket1 unaffected", v, 32'h420);
        irq_in[9] = 1'b0; irq_in[13] = 1'b1;
        wait_cyc(3);
        bus_rd(8'hE0, v); chk("R8 socket0 absent", v, 32'h420);
        bus_rd(8'hE4, v); chk("R8 socket1 present", v, 32'h400);
        irq_in[13] = 1'b0;
        wait_cyc(3);

        // R9 writable bits of socket words
        bus_wr(8'hE0, 32'hFFFF_FFFF);
        bus_rd(8'hE0, v); chk("R9 socket0 low bits only", v, 32'h43F);
        bus_rd(8'hE4, v); chk("R9 socket1 untouched", v, 32'h420);
        bus_wr(8'hE4, 32'h0000_0015);
        bus_rd(8'hE4, v); chk("R9 socket1 ctl", v, 32'h435);
        bus_wr(8'hE0, 32'h0);
        bus_rd(8'hE0, v); chk("R9 socket0 cleared", v, 32'h420);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule